// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block times the external memory bus cycles that a microcontroller core issues. It runs three kinds of cycle: data read, data write and code read. Each kind can run with or without an address-latch phase. The core offers a request: the cycle kind, whether to use the address-latch phase, the byte lanes, the address and the write data. The block then drives the address-latch pulse and the read strobe, the two byte-lane write strobes or the program-store strobe, along with the address and data drive enables. A one-cycle done pulse closes each cycle.

All timing is counted in ticks, and one tick is half a bus clock. An internal enable runs at twice the bus clock rate, and `TICK_DIV` sets how many `clk` cycles make one tick; with the default of 1, every `clk` edge is one tick. Separate configuration fields set the read length, the write length with and without the address-latch phase, the address-latch width, the write strobe width and the write hold. Address setup and the read strobe take whatever time is left over. The configuration is captured when a request is accepted. The `bus_wait` input stretches the active strobe one full bus clock at a time. A data read whose read strobe is only one bus clock wide cannot be stretched, and `bus_wait` has no effect on it.

Top module: `bus_cycle_seq`

## Requirements
- R1: A data read (kind 2'b00) without the latch phase lasts 2×(`cfg_rd_len`+1) ticks, i.e. 1 to 4 bus clocks, and `rd_stb` is high for the whole cycle.
- R2: With `req_ale`=1, a read lasts 2×(`cfg_rd_len_ale`+2) ticks. `ale` is high from the first tick for 1 tick (`cfg_ale_wide`=0) or 3 ticks (=1). One idle tick follows, and the strobe fills the rest of the cycle.
- R3: A data write (kind 2'b01) lasts 2×(code+2) ticks. The code is `cfg_wr_len` without the latch phase and `cfg_wr_len_ale` with it.
- R4: The write strobe is 2 ticks (`cfg_wr_wide`=0) or 4 ticks (=1) and ends 0 ticks (`cfg_wr_hold`=0) or 2 ticks (=1) before the cycle ends. Setup fills the time between the latch phase and the strobe. `data_oe` is high from the end of the latch phase to the end of the cycle.
- R5: A code read (kind 2'b10) has the same timing as a data read but drives `psen_stb` instead of `rd_stb`. At most one of `ale`, `rd_stb`, `psen_stb` and the write strobes is high at any time.
- R6: `bus_wait` is sampled on the last tick of the strobe. Each sample taken while it is high adds 2 ticks to the strobe, and to the cycle.
- R7: For a data read whose strobe is 2 ticks, `bus_wait` is ignored.
- R8: A request is refused if it is of kind 2'b11, if it is a read whose strobe would be 0 ticks or fewer, or if it is a write whose setup would be 0 ticks or fewer. For a refused request, `config_error` is high in the cycle after the request and no bus activity starts.
- R9: `addr_oe` is high for exactly the cycle's ticks. `done` pulses for one `clk` cycle right after the last tick. A request offered while a cycle is running is ignored.
- R10: After reset, all strobes, `addr_oe`, `data_oe`, `done`, `config_error` and `bus_addr` are zero.
- R11: `wrl_stb` follows `req_be[0]` and `wrh_stb` follows `req_be[1]`. While the cycle runs, `bus_addr` and `bus_wdata` hold the request's address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_kind | input | 2 | 00 data read, 01 data write, 10 code read, 11 reserved |
| req_ale | input | 1 | Use the address-latch phase |
| req_be | input | 2 | Byte lanes for writes (bit 0 low, bit 1 high) |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| cfg_rd_len | input | 2 | Read length code, no latch phase |
| cfg_rd_len_ale | input | 2 | Read length code, with latch phase |
| cfg_wr_len | input | 2 | Write length code, no latch phase |
| cfg_wr_len_ale | input | 2 | Write length code, with latch phase |
| cfg_ale_wide | input | 1 | Latch pulse 0.5 / 1.5 bus clocks |
| cfg_wr_wide | input | 1 | Write strobe 1 / 2 bus clocks |
| cfg_wr_hold | input | 1 | Write hold 0 / 1 bus clock |
| bus_wait | input | 1 | Stretch the active strobe |
| ale | output | 1 | Address-latch pulse |
| rd_stb | output | 1 | Data read strobe |
| wrl_stb | output | 1 | Low byte write strobe |
| wrh_stb | output | 1 | High byte write strobe |
| psen_stb | output | 1 | Code read strobe |
| addr_oe | output | 1 | Address drive enable, high while a cycle runs |
| data_oe | output | 1 | Write data drive enable |
| bus_addr | output | ADDR_W | Latched address |
| bus_wdata | output | DATA_W | Latched write data |
| done | output | 1 | Cycle complete pulse |
| config_error | output | 1 | Request refused for its timing |

## Verification
The bench runs every cycle kind, with and without the latch phase, through every length code, latch width, strobe width and hold setting. For each run it checks the tick at which each strobe starts and ends, the data-enable window and the tick at which `done` arrives. A design that forgets the half-clock gap after the latch pulse, or that reads the wrong length field, starts or ends the strobe one tick off. A design that subtracts the hold at the wrong point ends `data_oe` early. The combinations that leave no room for the strobe or the setup must be refused. If they are not, the design drives a strobe with a wrapped, huge tick count. The stretch tests look for two faults. One is a one-clock data read that wrongly grows under `bus_wait`. The other is a one-clock code fetch that wrongly does not.

// File: rtl/bus_seq_pkg.sv
// Shared types for the external bus cycle sequencer.
// Assumes: no phase of a cycle exceeds 2^TICK_W - 1 half-clock ticks.
package bus_seq_pkg;

    // Width of every half-clock tick count (longest phase is 8 ticks)
    localparam int TICK_W = 4;

    typedef enum logic [1:0] {
        K_DREAD  = 2'b00,
        K_DWRITE = 2'b01,
        K_CREAD  = 2'b10,
        K_RSVD   = 2'b11
    } bus_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } bus_phase_e;

    // Tick budget of each phase for one cycle
    typedef struct packed {
        logic [TICK_W-1:0] ale_t;
        logic [TICK_W-1:0] setup_t;
        logic [TICK_W-1:0] strobe_t;
        logic [TICK_W-1:0] hold_t;
        logic              can_stretch;
    } cycle_plan_t;

endpackage

// File: rtl/bus_tick_gen.sv
// Half-clock tick enable for the bus sequencer.
// Produces one tick every TICK_DIV clk cycles; with TICK_DIV = 1 it is
// high on every cycle. Assumes TICK_DIV >= 1.
module bus_tick_gen #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_en
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    // Count clk cycles and wrap after the last one of a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_en = (div_q == LAST);
endmodule

// File: rtl/bus_cycle_planner.sv
// Turns a request kind and the configuration fields into per-phase tick
// budgets. Read strobes and write setup take whatever is left of the cycle
// length; a non-positive remainder or the reserved kind marks the plan bad.
// Purely combinational; assumes the caller samples it only on acceptance.
module bus_cycle_planner
    import bus_seq_pkg::*;
(
    input  bus_kind_e   kind,
    input  logic        use_ale,
    input  logic [1:0]  cfg_rd_len,
    input  logic [1:0]  cfg_rd_len_ale,
    input  logic [1:0]  cfg_wr_len,
    input  logic [1:0]  cfg_wr_len_ale,
    input  logic        cfg_ale_wide,
    input  logic        cfg_wr_wide,
    input  logic        cfg_wr_hold,
    output cycle_plan_t plan,
    output logic        plan_bad
);
    int len_t;
    int ale_t;
    int set_t;
    int stb_t;
    int hld_t;

    // Split the cycle length into latch, setup, strobe and hold ticks
    always_comb begin
        ale_t    = use_ale ? (cfg_ale_wide ? 3 : 1) : 0;
        len_t    = 0;
        set_t    = 0;
        stb_t    = 0;
        hld_t    = 0;
        plan_bad = 1'b0;
        case (kind)
            K_DREAD, K_CREAD: begin
                len_t    = use_ale ? 2 * (int'(cfg_rd_len_ale) + 2)
                                   : 2 * (int'(cfg_rd_len) + 1);
                set_t    = use_ale ? 1 : 0;
                stb_t    = len_t - ale_t - set_t;
                plan_bad = (stb_t <= 0);
            end
            K_DWRITE: begin
                len_t    = 2 * (int'(use_ale ? cfg_wr_len_ale : cfg_wr_len) + 2);
                stb_t    = cfg_wr_wide ? 4 : 2;
                hld_t    = cfg_wr_hold ? 2 : 0;
                set_t    = len_t - stb_t - hld_t - ale_t;
                plan_bad = (set_t <= 0);
            end
            default: plan_bad = 1'b1;
        endcase
    end

    // Pack the budgets, zeroed when the request will be refused
    always_comb begin
        plan.ale_t       = plan_bad ? '0 : TICK_W'(ale_t);
        plan.setup_t     = plan_bad ? '0 : TICK_W'(set_t);
        plan.strobe_t    = plan_bad ? '0 : TICK_W'(stb_t);
        plan.hold_t      = plan_bad ? '0 : TICK_W'(hld_t);
        plan.can_stretch = (kind != K_DREAD) || (stb_t > 2);
    end
endmodule

// File: rtl/bus_phase_engine.sv
// Phase sequencer: walks latch, setup, strobe and hold phases using the
// plan captured at start, skipping empty phases. On the last strobe tick
// it samples bus_wait and adds one full bus clock (two ticks) when the
// plan allows stretching. Assumes start only in PH_IDLE on a tick.
module bus_phase_engine
    import bus_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        start,
    input  logic        refuse,
    input  cycle_plan_t plan_in,
    input  logic        bus_wait,
    output bus_phase_e  phase,
    output logic        done,
    output logic        config_error
);
    cycle_plan_t       plan_q;
    logic [TICK_W-1:0] cnt_q;

    // Advance the phase and its tick counter; flag completion and refusal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            cnt_q        <= '0;
            plan_q       <= '0;
            done         <= 1'b0;
            config_error <= 1'b0;
        end else begin
            done         <= 1'b0;
            config_error <= refuse;
            if (start) begin
                plan_q <= plan_in;
                if (plan_in.ale_t != '0) begin
                    phase <= PH_ALE;
                    cnt_q <= plan_in.ale_t;
                end else if (plan_in.setup_t != '0) begin
                    phase <= PH_SETUP;
                    cnt_q <= plan_in.setup_t;
                end else begin
                    phase <= PH_STROBE;
                    cnt_q <= plan_in.strobe_t;
                end
            end else if (tick_en && phase != PH_IDLE) begin
                if (cnt_q > TICK_W'(1)) begin
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    case (phase)
                        PH_ALE: begin
                            if (plan_q.setup_t != '0) begin
                                phase <= PH_SETUP;
                                cnt_q <= plan_q.setup_t;
                            end else begin
                                phase <= PH_STROBE;
                                cnt_q <= plan_q.strobe_t;
                            end
                        end
                        PH_SETUP: begin
                            phase <= PH_STROBE;
                            cnt_q <= plan_q.strobe_t;
                        end
                        PH_STROBE: begin
                            if (bus_wait && plan_q.can_stretch) begin
                                cnt_q <= TICK_W'(2);
                            end else if (plan_q.hold_t != '0) begin
                                phase <= PH_HOLD;
                                cnt_q <= plan_q.hold_t;
                            end else begin
                                phase <= PH_IDLE;
                                done  <= 1'b1;
                            end
                        end
                        default: begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/bus_pin_driver.sv
// Captures the accepted request's kind, lanes, address and data, and
// decodes the current phase into the bus strobes and drive enables.
// Assumes start is asserted only when a cycle is accepted.
module bus_pin_driver
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  bus_kind_e         req_kind,
    input  logic [1:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  bus_phase_e        phase,
    output logic              ale,
    output logic              rd_stb,
    output logic              wrl_stb,
    output logic              wrh_stb,
    output logic              psen_stb,
    output logic              addr_oe,
    output logic              data_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    bus_kind_e  kind_q;
    logic [1:0] be_q;

    // Hold the request fields for the length of the cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= K_DREAD;
            be_q      <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (start) begin
            kind_q    <= req_kind;
            be_q      <= req_be;
            bus_addr  <= req_addr;
            bus_wdata <= req_wdata;
        end
    end

    // Map phase and kind onto the pins
    always_comb begin
        ale      = (phase == PH_ALE);
        rd_stb   = (phase == PH_STROBE) && (kind_q == K_DREAD);
        psen_stb = (phase == PH_STROBE) && (kind_q == K_CREAD);
        wrl_stb  = (phase == PH_STROBE) && (kind_q == K_DWRITE) && be_q[0];
        wrh_stb  = (phase == PH_STROBE) && (kind_q == K_DWRITE) && be_q[1];
        addr_oe  = (phase != PH_IDLE);
        data_oe  = (kind_q == K_DWRITE) &&
                   (phase == PH_SETUP || phase == PH_STROBE || phase == PH_HOLD);
    end
endmodule

// File: rtl/bus_cycle_seq.sv
// Top of the external bus cycle sequencer. Accepts a request on a tick
// while idle, refuses it when its timing plan is bad, and otherwise runs
// the cycle through the phase engine and pin driver.
// Assumes configuration is stable on the tick a request is accepted.
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int TICK_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_ale,
    input  logic [1:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cfg_rd_len,
    input  logic [1:0]        cfg_rd_len_ale,
    input  logic [1:0]        cfg_wr_len,
    input  logic [1:0]        cfg_wr_len_ale,
    input  logic              cfg_ale_wide,
    input  logic              cfg_wr_wide,
    input  logic              cfg_wr_hold,
    input  logic              bus_wait,
    output logic              ale,
    output logic              rd_stb,
    output logic              wrl_stb,
    output logic              wrh_stb,
    output logic              psen_stb,
    output logic              addr_oe,
    output logic              data_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              done,
    output logic              config_error
);
    logic        tick_en;
    logic        plan_bad;
    logic        start;
    logic        refuse;
    cycle_plan_t plan;
    bus_phase_e  phase;
    bus_kind_e   kind_in;

    assign kind_in = bus_kind_e'(req_kind);

    // Accept or refuse a request only while idle and on a tick
    always_comb begin
        start  = tick_en && (phase == PH_IDLE) && req_valid && !plan_bad;
        refuse = tick_en && (phase == PH_IDLE) && req_valid &&  plan_bad;
    end

    bus_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en)
    );

    bus_cycle_planner u_plan (
        .kind           (kind_in),
        .use_ale        (req_ale),
        .cfg_rd_len     (cfg_rd_len),
        .cfg_rd_len_ale (cfg_rd_len_ale),
        .cfg_wr_len     (cfg_wr_len),
        .cfg_wr_len_ale (cfg_wr_len_ale),
        .cfg_ale_wide   (cfg_ale_wide),
        .cfg_wr_wide    (cfg_wr_wide),
        .cfg_wr_hold    (cfg_wr_hold),
        .plan           (plan),
        .plan_bad       (plan_bad)
    );

    bus_phase_engine u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .start        (start),
        .refuse       (refuse),
        .plan_in      (plan),
        .bus_wait     (bus_wait),
        .phase        (phase),
        .done         (done),
        .config_error (config_error)
    );

    bus_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_kind  (kind_in),
        .req_be    (req_be),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase     (phase),
        .ale       (ale),
        .rd_stb    (rd_stb),
        .wrl_stb   (wrl_stb),
        .wrh_stb   (wrh_stb),
        .psen_stb  (psen_stb),
        .addr_oe   (addr_oe),
        .data_oe   (data_oe),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );
endmodule

// File: rtl/bus_cycle_seq_chk.sv
// Protocol checker for bus_cycle_seq, attached with bind below.
// Observes the top-level pins only.
module bus_cycle_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic              rd_stb,
    input logic              wrl_stb,
    input logic              wrh_stb,
    input logic              psen_stb,
    input logic              addr_oe,
    input logic              data_oe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              done,
    input logic              config_error
);
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ale, rd_stb, psen_stb, wrl_stb | wrh_stb}));

    p_write_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrl_stb || wrh_stb) |-> data_oe);

    p_ale_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (!data_oe && addr_oe));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!addr_oe && $past(addr_oe)));

    p_refuse_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> !addr_oe);

    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe && $past(addr_oe)) |-> $stable(bus_addr));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ale          (ale),
    .rd_stb       (rd_stb),
    .wrl_stb      (wrl_stb),
    .wrh_stb      (wrh_stb),
    .psen_stb     (psen_stb),
    .addr_oe      (addr_oe),
    .data_oe      (data_oe),
    .bus_addr     (bus_addr),
    .done         (done),
    .config_error (config_error)
);

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
// Sweeps every cycle kind and configuration code through bus_cycle_seq
// and compares strobe tick positions with arithmetic expectations.
module sim_bus_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_ale = 1'b0;
    logic [1:0]  req_be = 2'b00;
    logic [15:0] req_addr = 16'h0;
    logic [15:0] req_wdata = 16'h0;
    logic [1:0]  cfg_rd_len = 2'b00;
    logic [1:0]  cfg_rd_len_ale = 2'b00;
    logic [1:0]  cfg_wr_len = 2'b00;
    logic [1:0]  cfg_wr_len_ale = 2'b00;
    logic        cfg_ale_wide = 1'b0;
    logic        cfg_wr_wide = 1'b0;
    logic        cfg_wr_hold = 1'b0;
    logic        bus_wait = 1'b0;
    logic        ale, rd_stb, wrl_stb, wrh_stb, psen_stb;
    logic        addr_oe, data_oe, done, config_error;
    logic [15:0] bus_addr, bus_wdata;

    int checks = 0;
    int errors = 0;
    int run_no = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ale(req_ale), .req_be(req_be), .req_addr(req_addr),
        .req_wdata(req_wdata), .cfg_rd_len(cfg_rd_len),
        .cfg_rd_len_ale(cfg_rd_len_ale), .cfg_wr_len(cfg_wr_len),
        .cfg_wr_len_ale(cfg_wr_len_ale), .cfg_ale_wide(cfg_ale_wide),
        .cfg_wr_wide(cfg_wr_wide), .cfg_wr_hold(cfg_wr_hold),
        .bus_wait(bus_wait), .ale(ale), .rd_stb(rd_stb), .wrl_stb(wrl_stb),
        .wrh_stb(wrh_stb), .psen_stb(psen_stb), .addr_oe(addr_oe),
        .data_oe(data_oe), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .done(done), .config_error(config_error)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s run %0d %s: actual %0d expected %0d", rq, run_no, what, act, exp);
        end
    endtask

    // One request; kind 0 read, 1 write, 2 code read, 3 reserved
    task automatic run_cycle(input int kind, input int use_ale, input int code,
                             input int aw, input int ww, input int hd,
                             input int be, input int nwait, input bit poke);
        int L, A, P, X, H, s, ext, lim;
        bit bad, can;
        int f_ale = -1, l_ale = -1, f_stb = -1, l_stb = -1;
        int f_doe = -1, l_doe = -1, f_done = -1, oe_cnt = 0;
        bit other = 0, wl = 0, wh = 0, err0 = 0, addr_bad = 0, data_bad = 0;
        string tg_stb, tg_len;
        logic [15:0] addr, wdata;
        run_no++;
        A = use_ale != 0 ? (aw != 0 ? 3 : 1) : 0;
        L = 4; P = 0; X = 0; H = 0;
        if (kind == 1) begin
            L = 2 * (code + 2); X = ww != 0 ? 4 : 2; H = hd != 0 ? 2 : 0;
            P = L - X - H - A; bad = (P <= 0);
        end else if (kind == 3) begin
            bad = 1'b1;
        end else begin
            L = use_ale != 0 ? 2 * (code + 2) : 2 * (code + 1);
            P = use_ale; X = L - A - P; bad = (X <= 0);
        end
        can = !(kind == 0 && X <= 2);
        ext = can ? nwait : 0;
        s = A + P;
        tg_len = kind == 1 ? "R3" : (use_ale != 0 ? "R2" : "R1");
        if (nwait > 0) tg_stb = can ? "R6" : "R7";
        else if (kind == 1) tg_stb = "R4";
        else if (kind == 2) tg_stb = "R5";
        else tg_stb = tg_len;
        addr  = 16'(32'h2000 + run_no * 13);
        wdata = 16'(32'h5A00 ^ run_no);

        @(negedge clk);
        cfg_rd_len = 2'(3 - code); cfg_rd_len_ale = 2'(3 - code);
        cfg_wr_len = 2'(3 - code); cfg_wr_len_ale = 2'(3 - code);
        if (kind == 1) begin
            if (use_ale != 0) cfg_wr_len_ale = 2'(code); else cfg_wr_len = 2'(code);
        end else begin
            if (use_ale != 0) cfg_rd_len_ale = 2'(code); else cfg_rd_len = 2'(code);
        end
        cfg_ale_wide = aw != 0; cfg_wr_wide = ww != 0; cfg_wr_hold = hd != 0;
        req_kind = 2'(kind); req_ale = use_ale != 0; req_be = 2'(be);
        req_addr = addr; req_wdata = wdata; req_valid = 1'b1;

        lim = bad ? 4 : L + 2 * ext + 2;
        for (int i = 0; i <= lim; i++) begin
            bit gs;
            @(negedge clk);
            gs = kind == 0 ? rd_stb : (kind == 2 ? psen_stb : (wrl_stb | wrh_stb));
            if (kind == 3) gs = 1'b0;
            if (ale) begin if (f_ale < 0) f_ale = i; l_ale = i; end
            if (gs) begin if (f_stb < 0) f_stb = i; l_stb = i; end
            if ((kind != 0 && rd_stb) || (kind != 2 && psen_stb) ||
                (kind != 1 && (wrl_stb || wrh_stb))) other = 1'b1;
            if (wrl_stb) wl = 1'b1;
            if (wrh_stb) wh = 1'b1;
            if (data_oe) begin if (f_doe < 0) f_doe = i; l_doe = i; end
            if (done && f_done < 0) f_done = i;
            if (addr_oe) oe_cnt++;
            if (i == 0) err0 = config_error;
            if (addr_oe && bus_addr != addr) addr_bad = 1'b1;
            if (gs && kind == 1 && bus_wdata != wdata) data_bad = 1'b1;
            if (i == 0) req_valid = 1'b0;
            if (poke && i == 1) begin
                req_valid = 1'b1; req_kind = kind == 1 ? 2'b00 : 2'b01; req_be = 2'b11;
            end
            if (poke && i == 2) req_valid = 1'b0;
            bus_wait = (nwait > 0) && (i < s + X - 1 + 2 * nwait);
        end
        bus_wait = 1'b0;

        if (bad) begin
            check("R8", "config_error after refused request", int'(err0), 1);
            check("R8", "addr_oe ticks of refused request", oe_cnt, 0);
            check("R8", "strobes on refused request", int'(other | (f_ale >= 0)), 0);
        end else begin
            check(tg_stb, "strobe first tick", f_stb, s);
            check(tg_stb, "strobe last tick", l_stb, s + X - 1 + 2 * ext);
            check(tg_len, "done tick", f_done, L + 2 * ext);
            check("R9", "addr_oe tick count", oe_cnt, L + 2 * ext);
            if (use_ale != 0) begin
                check("R2", "ale first tick", f_ale, 0);
                check("R2", "ale last tick", l_ale, A - 1);
            end else begin
                check(tg_len, "ale absent", f_ale, -1);
            end
            check(poke ? "R9" : "R5", "foreign strobe seen", int'(other), 0);
            if (kind == 1) begin
                check("R4", "data_oe first tick", f_doe, A);
                check("R4", "data_oe last tick", l_doe, L - 1 + 2 * ext);
                check("R11", "low lane strobe", int'(wl), be & 1);
                check("R11", "high lane strobe", int'(wh), (be >> 1) & 1);
                check("R11", "write data mismatch", int'(data_bad), 0);
            end else begin
                check(tg_len, "data_oe on read", f_doe, -1);
            end
            check("R11", "address mismatch", int'(addr_bad), 0);
            check("R8", "config_error on good request", int'(err0), 0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10", "strobes after reset",
              int'({ale, rd_stb, wrl_stb, wrh_stb, psen_stb}), 0);
        check("R10", "enables after reset", int'({addr_oe, data_oe, done, config_error}), 0);
        check("R10", "bus_addr after reset", int'(bus_addr), 0);

        // Full sweep of kinds and configuration codes
        for (int k = 0; k < 3; k++)
            for (int a = 0; a < 2; a++)
                for (int c = 0; c < 4; c++)
                    for (int w = 0; w < 2; w++)
                        for (int ww = 0; ww < 2; ww++)
                            for (int h = 0; h < 2; h++)
                                run_cycle(k, a, c, w, ww, h, 1 + (run_no % 3), 0, 1'b0);

        run_cycle(3, 0, 2, 0, 0, 0, 3, 0, 1'b0);       // R8 reserved kind
        run_cycle(0, 0, 1, 0, 0, 0, 1, 2, 1'b0);       // R6 read, 2-clock strobe
        run_cycle(0, 1, 0, 0, 0, 0, 1, 2, 1'b0);       // R7 one-clock RD with latch
        run_cycle(0, 0, 0, 0, 0, 0, 1, 3, 1'b0);       // R7 one-clock RD no latch
        run_cycle(2, 1, 0, 0, 0, 0, 1, 3, 1'b0);       // R6 one-clock PSEN stretches
        run_cycle(1, 0, 2, 0, 1, 1, 3, 1, 1'b0);       // R6 write stretch with hold
        run_cycle(0, 0, 3, 0, 0, 0, 1, 0, 1'b1);       // R9 request while busy
        run_cycle(1, 0, 3, 0, 0, 0, 3, 0, 1'b1);       // R9 request while busy

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule